// File: doc/BRIEF.md
# PLL Unlock Detector with Violation Stretching

This block judges whether a frequency synthesizer's loop is locked by timing the phase-error pulse from the phase comparator. It counts reference-clock cycles while that pulse stays high and compares the count with one of two programmable limits. A 2-bit mode input picks one of four behaviours. Detection can be switched off. The raw phase-error pulse can be forwarded unchanged. Otherwise a narrow or a wide width window applies.

In the windowed modes, a pulse longer than the limit is a violation. A violation sets an unlock flag, and the flag stays set until two ticks of a free-running coarse time base (nominally 1 ms) have passed with no new violation. The indication therefore lasts between one and two tick periods. The unlock flag drives an active-high unlock output and an active-high lock status bit, which is its inverse. A separate detection output carries the same information together with an output-enable. That enable is low when detection is off, so an external pin can float.

Top module: `pll_unlock_det`

## Requirements
- R1: While reset is asserted and right after it is released, unlock_o is 0 and lock_o is 1.
- R2: With mode_i = 2'b00 (off), det_oe_o is 0, unlock_o is 0 and lock_o is 1, whatever phase_err_i does.
- R3: With mode_i = 2'b01 (raw), det_o and unlock_o equal phase_err_i in the same cycle, and det_oe_o is 1.
- R4: With mode_i = 2'b10 (narrow, limit NARROW_CYC) or 2'b11 (wide, limit WIDE_CYC), a phase-error pulse that is high for at most the limit in clock cycles never sets unlock_o. A longer pulse sets unlock_o in the cycle after its first cycle beyond the limit.
- R5: The tick time base fires once every TICK_CYC cycles. After the last violation, unlock_o stays 1 for at least TICK_CYC cycles and is 0 no later than 2*TICK_CYC+1 cycles later.
- R6: A new violation while unlock_o is held restarts the hold, so the two-tick wait begins again from that violation.
- R7: In the windowed modes det_oe_o is 1 and det_o equals unlock_o. In every mode lock_o is the inverse of unlock_o.
- R8: A change of mode_i clears the unlock flag by the next clock edge. It also discards any partly counted pulse width, so counting restarts in the cycle after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Detection mode: 00 off, 01 raw, 10 narrow window, 11 wide window |
| phase_err_i | input | 1 | Phase-error pulse from the phase comparator, high while an error is present |
| unlock_o | output | 1 | Unlock flag, 1 while the loop is judged unlocked |
| lock_o | output | 1 | Lock status bit, 0 while unlocked |
| det_o | output | 1 | Detection output value |
| det_oe_o | output | 1 | Detection output enable, 0 releases the output |

## Verification
In raw mode unlock_o follows the error input combinationally, so the bench checks it in the same cycle. In the windowed modes the flag is registered. The bench drives a pulse for N rising edges and samples at the following falling edge, where unlock_o already shows whether the N-th cycle went past the limit. The hold is checked at two points: TICK_CYC edges after the violation, where the flag must still be set, and 2*TICK_CYC+1 edges after it, where it must be clear. A mode change is checked one edge later. All sampling happens on falling edges, and inputs change only right after a sample.

// File: rtl/pud_pkg.sv
package pud_pkg;

  typedef enum logic [1:0] {
    MODE_OFF    = 2'b00,
    MODE_RAW    = 2'b01,
    MODE_NARROW = 2'b10,
    MODE_WIDE   = 2'b11
  } det_mode_e;

endpackage

// File: rtl/pud_tick_gen.sv
module pud_tick_gen #(
  parameter int unsigned TICK_CYC = 50000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned TW = (TICK_CYC > 1) ? $clog2(TICK_CYC) : 1;
  localparam logic [TW-1:0] LAST = TW'(TICK_CYC - 1);

  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (cnt_q == LAST) cnt_d = '0;
    else               cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign tick_o = (cnt_q == LAST);

  generate
    if (TICK_CYC > 1) begin : g_tick_chk
      AST_TICK_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o); // R5
    end
  endgenerate

endmodule

// File: rtl/pud_width_meas.sv
module pud_width_meas #(
  parameter int unsigned CW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          err_i,
  input  logic          en_i,
  input  logic          clr_i,
  input  logic [CW-1:0] thr_i,
  output logic          viol_o
);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic [CW-1:0] wcnt_q, wcnt_d;

  always_comb begin
    if (clr_i || !err_i)   wcnt_d = '0;
    else if (wcnt_q != CMAX) wcnt_d = wcnt_q + 1'b1;
    else                   wcnt_d = wcnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wcnt_q <= '0;
    else         wcnt_q <= wcnt_d;
  end

  assign viol_o = en_i && !clr_i && err_i && (wcnt_q >= thr_i);

  AST_NO_VIOL_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!err_i || !en_i) |-> !viol_o); // R4
  AST_CLR_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (wcnt_q <= 1)); // R8

endmodule

// File: rtl/pud_stretch.sv
module pud_stretch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic viol_i,
  input  logic tick_i,
  output logic unlock_o
);
  logic unlock_q, unlock_d;
  logic seen_q, seen_d;

  always_comb begin
    unlock_d = unlock_q;
    seen_d   = seen_q;
    if (clr_i) begin
      unlock_d = 1'b0;
      seen_d   = 1'b0;
    end else if (viol_i) begin
      unlock_d = 1'b1;
      seen_d   = 1'b0;
    end else if (unlock_q && tick_i) begin
      if (seen_q) begin
        unlock_d = 1'b0;
        seen_d   = 1'b0;
      end else begin
        seen_d   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      unlock_q <= 1'b0;
      seen_q   <= 1'b0;
    end else begin
      unlock_q <= unlock_d;
      seen_q   <= seen_d;
    end
  end

  assign unlock_o = unlock_q;

  AST_VIOL_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (viol_i && !clr_i) |=> unlock_q); // R4
  AST_HOLD_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unlock_q && !tick_i && !clr_i) |=> unlock_q); // R5
  AST_CLR_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !unlock_q); // R8

endmodule

// File: rtl/pll_unlock_det.sv
module pll_unlock_det
  import pud_pkg::*;
#(
  parameter int unsigned NARROW_CYC = 27,
  parameter int unsigned WIDE_CYC   = 55,
  parameter int unsigned TICK_CYC   = 50000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic       phase_err_i,
  output logic       unlock_o,
  output logic       lock_o,
  output logic       det_o,
  output logic       det_oe_o
);
  localparam int unsigned CW = $clog2(WIDE_CYC + 2);
  localparam logic [CW-1:0] THR_N = CW'(NARROW_CYC);
  localparam logic [CW-1:0] THR_W = CW'(WIDE_CYC);

  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  det_mode_e mode_cur, mode_q;
  logic      mode_chg;
  logic      windowed;
  logic [CW-1:0] thr;
  logic      viol;
  logic      tick;
  logic      held;

  assign mode_cur = det_mode_e'(mode_i);
  assign mode_chg = (mode_cur != mode_q);
  assign windowed = (mode_cur == MODE_NARROW) || (mode_cur == MODE_WIDE);
  assign thr      = (mode_cur == MODE_WIDE) ? THR_W : THR_N;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_OFF;
    else        mode_q <= mode_cur;
  end

  pud_tick_gen #(.TICK_CYC(TICK_CYC)) tick_i (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .tick_o (tick)
  );

  pud_width_meas #(.CW(CW)) meas_i (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .err_i  (phase_err_i),
    .en_i   (windowed),
    .clr_i  (mode_chg),
    .thr_i  (thr),
    .viol_o (viol)
  );

  pud_stretch stretch_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .clr_i    (mode_chg || !windowed),
    .viol_i   (viol),
    .tick_i   (tick),
    .unlock_o (held)
  );

  always_comb begin
    unique case (mode_cur)
      MODE_OFF: begin
        unlock_o = 1'b0;
        det_oe_o = 1'b0;
      end
      MODE_RAW: begin
        unlock_o = phase_err_i;
        det_oe_o = 1'b1;
      end
      default: begin
        unlock_o = held;
        det_oe_o = 1'b1;
      end
    endcase
  end

  assign det_o  = unlock_o && det_oe_o;
  assign lock_o = !unlock_o;

  AST_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_n)
    (mode_q == MODE_OFF && mode_cur == MODE_OFF) |-> !held); // R2
  AST_MODE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_n)
    mode_chg |=> !held); // R8
  AST_WIN_DET_MATCH: assert property (@(posedge clk_i) disable iff (!rst_n)
    windowed |-> (det_o == held)); // R7

endmodule

// File: tb/pll_unlock_det_tb_top.sv
module pll_unlock_det_tb_top;
  localparam int unsigned NC = 4;
  localparam int unsigned WC = 8;
  localparam int unsigned TC = 40;

  logic       clk;
  logic       rst_n;
  logic [1:0] mode;
  logic       err;
  logic       unlock, lock, det, det_oe;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  pll_unlock_det #(.NARROW_CYC(NC), .WIDE_CYC(WC), .TICK_CYC(TC)) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .mode_i      (mode),
    .phase_err_i (err),
    .unlock_o    (unlock),
    .lock_o      (lock),
    .det_o       (det),
    .det_oe_o    (det_oe)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct packed {
    logic [1:0] md;
    logic [7:0] len;
    logic       exp;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{2'b10, 8'd1,  1'b0},
    '{2'b10, 8'd4,  1'b0},
    '{2'b10, 8'd5,  1'b1},
    '{2'b10, 8'd12, 1'b1},
    '{2'b11, 8'd4,  1'b0},
    '{2'b11, 8'd8,  1'b0},
    '{2'b11, 8'd9,  1'b1},
    '{2'b11, 8'd20, 1'b1},
    '{2'b00, 8'd30, 1'b0}
  };

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic wait_neg(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int n);
    err = 1'b1;
    wait_neg(n);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    mode  = 2'b10;
    err   = 1'b0;
    wait_neg(3);
    chk("R1 unlock in reset", unlock, 1'b0);
    chk("R1 lock in reset", lock, 1'b1);
    rst_n = 1'b1;
    wait_neg(4);
    chk("R1 unlock after reset", unlock, 1'b0);
    chk("R1 lock after reset", lock, 1'b1);

    for (int i = 0; i < NV; i++) begin
      mode = VEC[i].md;
      wait_neg(3);
      pulse(int'(VEC[i].len));
      chk(VEC[i].md == 2'b00 ? "R2 unlock off" : "R4 unlock", unlock, VEC[i].exp);
      chk("R7 lock", lock, !VEC[i].exp);
      chk(VEC[i].md == 2'b00 ? "R2 det_oe" : "R7 det_oe", det_oe, VEC[i].md != 2'b00);
      if (VEC[i].md != 2'b00) chk("R7 det", det, VEC[i].exp);
      err = 1'b0;
      wait_neg(2 * TC + 4);
    end

    // R3 raw passthrough
    mode = 2'b01;
    wait_neg(2);
    err = 1'b1;
    #2;
    chk("R3 unlock high", unlock, 1'b1);
    chk("R3 det high", det, 1'b1);
    chk("R3 det_oe", det_oe, 1'b1);
    wait_neg(1);
    err = 1'b0;
    #2;
    chk("R3 unlock low", unlock, 1'b0);
    chk("R3 lock", lock, 1'b1);

    // R5 hold window
    mode = 2'b10;
    wait_neg(3);
    pulse(6);
    err = 1'b0;
    chk("R5 set", unlock, 1'b1);
    wait_neg(TC);
    chk("R5 held one period", unlock, 1'b1);
    wait_neg(TC + 1);
    chk("R5 cleared", unlock, 1'b0);

    // R6 restart on new violation
    wait_neg(2);
    pulse(6);
    err = 1'b0;
    wait_neg(TC);
    pulse(6);
    err = 1'b0;
    wait_neg(TC);
    chk("R6 restarted hold", unlock, 1'b1);
    wait_neg(TC + 1);
    chk("R6 cleared after restart", unlock, 1'b0);

    // R8 mode change clears flag
    pulse(6);
    err = 1'b0;
    chk("R8 set before change", unlock, 1'b1);
    mode = 2'b11;
    wait_neg(1);
    chk("R8 flag cleared", unlock, 1'b0);

    // R8 width count restarts on mode change
    mode = 2'b10;
    wait_neg(3);
    pulse(3);
    mode = 2'b11;
    wait_neg(8);
    chk("R8 count restarted", unlock, 1'b0);
    err = 1'b0;
    wait_neg(2);
    chk("R8 still locked", lock, 1'b1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule